// File: doc/BRIEF.md
# Operating-Mode Port Pin Multiplexer

This block decides what three 8-bit microcontroller ports present at their pins. It also holds the data and direction registers the CPU writes to control them. A mode input selects between two cases. In single-chip operation, the "high" port is an output-only register and the "bidirectional" port is general-purpose I/O with a direction bit per line. In expanded multiplexed operation, the high port carries the upper address byte. The bidirectional port then becomes a time-shared bus: it carries the low address byte, then write data, internal read data, or nothing while it samples external read data.

The third port, the timer port, works the same way in both modes. Three of its lines are fixed inputs that feed the capture logic. Three are fixed outputs. Lines 7 and 3 take their direction from a control register. Line 3 is shared: it acts either as a fourth capture input or as a fifth compare output. A compare channel that is enabled overrides the latched data on any output-capable line it owns. The CPU core, the timer engines and the pad cells are outside this block.

Top module: `pinmux_ports`

## Requirements
- R1: After reset, all data, direction and control registers read 0. The high port outputs 0, the bidirectional port drives nothing in single-chip mode, and the timer-port enables are 0x70.
- R2: With `mode_exp`=0, `hp_out` equals the high-data register (address 2). Reading that register returns the value last written.
- R3: With `mode_exp`=1, `hp_out` equals `bus_addr[15:8]`. Writes to the high-data register are still latched and appear once the mode returns to 0.
- R4: With `mode_exp`=0, `cp_oe` equals the direction register (address 4, 1 = output) and `cp_out` equals the data register (address 3). A data read returns the latched bit where the direction bit is 1 and the pin level where it is 0.
- R5: With `mode_exp`=1 and `bus_as`=1, the bidirectional port drives `bus_addr[7:0]` on all lines.
- R6: With `mode_exp`=1, `bus_as`=0, `bus_eclk`=1 and `bus_rnw`=0, the port drives `bus_wdata` on all lines.
- R7: With `mode_exp`=1, `bus_as`=0 and no write or visibility drive, `cp_oe` is 0. `bus_rdata` always equals `cp_in`.
- R8: With `mode_exp`=1, `bus_as`=0, `bus_eclk`=1, `bus_rnw`=1, `irv_en`=1 and `int_rd`=1, the port drives `int_rdata`. If either `irv_en` or `int_rd` is 0, it drives nothing.
- R9: Timer-port lines 6:4 are always outputs and lines 2:0 are always inputs. The direction of line 7 is control bit 7 and the direction of line 3 is control bit 3 (control register, address 1).
- R10: A timer-data read (address 0) returns the latched bit on output lines and the pin level on input lines.
- R11: On an output line, `tmr_oc_en[i]`=1 drives `tmr_oc_lvl[i]`; otherwise the latched data is driven. Lines 7 and 6:4 accept the override. Line 3 accepts it only when control bit 2 is 1.
- R12: `tmr_ic` equals the pin level on lines 2:0. It equals the pin level on line 3 only when control bit 2 is 0. All other `tmr_ic` bits are 0.
- R13: The timer-port behaviour is identical for both values of `mode_exp`.
- R14: A control register read returns only bits 7, 3 and 2. Addresses 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_exp | input | 1 | 1 = expanded multiplexed, 0 = single-chip |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_addr | input | 16 | CPU bus address |
| bus_wdata | input | 8 | CPU write data for the external bus |
| bus_rnw | input | 1 | 1 = read cycle |
| bus_as | input | 1 | Address strobe |
| bus_eclk | input | 1 | Bus data phase clock |
| irv_en | input | 1 | Internal read visibility enable |
| int_rd | input | 1 | Current read targets an internal address |
| int_rdata | input | 8 | Internal read data |
| bus_rdata | output | 8 | Sampled external data |
| hp_out | output | 8 | High port pin values |
| cp_in | input | 8 | Bidirectional port pin levels |
| cp_out | output | 8 | Bidirectional port drive values |
| cp_oe | output | 8 | Bidirectional port drive enables |
| tp_in | input | 8 | Timer port pin levels |
| tp_out | output | 8 | Timer port drive values |
| tp_oe | output | 8 | Timer port drive enables |
| tmr_oc_en | input | 8 | Per-line compare override enable |
| tmr_oc_lvl | input | 8 | Per-line compare level |
| tmr_ic | output | 8 | Capture inputs to the timer |

## Verification
Some properties are checked on every cycle. These are the fixed timer-port directions, the full-width address drive while the strobe is high, and bus release on external reads. Register writes are also checked to reach the high port and the bidirectional direction enables one cycle later. Read-back mixing of pin and latch, the compare override on line 3 under both select values, capture gating, and the equality of timer-port behaviour across modes only show up in the bench sweeps. Those sweeps compute each expected word arithmetically.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
   typedef enum logic [2:0] {
      RA_TDATA = 3'd0,
      RA_TCTRL = 3'd1,
      RA_HDATA = 3'd2,
      RA_CDATA = 3'd3,
      RA_CDIR  = 3'd4
   } reg_addr_e;

   localparam int TP_W       = 8;
   localparam int TC_DIR_HI  = 7;
   localparam int TC_DIR_SH  = 3;
   localparam int TC_SH_OC   = 2;
   localparam int SHARED_PIN = 3;
   localparam int PROG_PIN   = 7;

   typedef struct packed {
      logic dir_hi;
      logic dir_sh;
      logic sh_oc;
   } tctrl_t;
endpackage

// File: rtl/port_hi_mux.sv
module port_hi_mux #(
   parameter int DW = 8
) (
   input  logic          mode_exp,
   input  logic [DW-1:0] data_q,
   input  logic [DW-1:0] addr_hi,
   output logic [DW-1:0] pin_out
);
   always_comb begin
      pin_out = mode_exp ? addr_hi : data_q;
   end
endmodule

// File: rtl/port_bidir_mux.sv
module port_bidir_mux #(
   parameter int DW = 8
) (
   input  logic          mode_exp,
   input  logic [DW-1:0] data_q,
   input  logic [DW-1:0] dir_q,
   input  logic [DW-1:0] addr_lo,
   input  logic [DW-1:0] wdata,
   input  logic          rnw,
   input  logic          as_hi,
   input  logic          eclk,
   input  logic          irv_en,
   input  logic          int_rd,
   input  logic [DW-1:0] int_rdata,
   input  logic [DW-1:0] pin_in,
   output logic [DW-1:0] pin_out,
   output logic [DW-1:0] pin_oe,
   output logic [DW-1:0] rd_val,
   output logic [DW-1:0] ext_rdata
);
   typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_WDATA, PH_VIS} phase_e;
   phase_e ph;

   always_comb begin
      if (as_hi)                          ph = PH_ADDR;
      else if (eclk && !rnw)              ph = PH_WDATA;
      else if (eclk && irv_en && int_rd)  ph = PH_VIS;
      else                                ph = PH_IDLE;
   end

   always_comb begin
      if (!mode_exp) begin
         pin_out = data_q;
         pin_oe  = dir_q;
      end else begin
         unique case (ph)
            PH_ADDR:  begin pin_out = addr_lo;   pin_oe = '1; end
            PH_WDATA: begin pin_out = wdata;     pin_oe = '1; end
            PH_VIS:   begin pin_out = int_rdata; pin_oe = '1; end
            default:  begin pin_out = '0;        pin_oe = '0; end
         endcase
      end
   end

   assign rd_val    = (data_q & dir_q) | (pin_in & ~dir_q);
   assign ext_rdata = pin_in;
endmodule

// File: rtl/port_timer_mux.sv
module port_timer_mux
   import pinmux_pkg::*;
#(
   parameter logic [TP_W-1:0] FIX_OUT = 8'h70,
   parameter logic [TP_W-1:0] FIX_IN  = 8'h07
) (
   input  logic [TP_W-1:0] data_q,
   input  tctrl_t          ctl,
   input  logic [TP_W-1:0] pin_in,
   input  logic [TP_W-1:0] oc_en,
   input  logic [TP_W-1:0] oc_lvl,
   output logic [TP_W-1:0] pin_out,
   output logic [TP_W-1:0] pin_oe,
   output logic [TP_W-1:0] rd_val,
   output logic [TP_W-1:0] ic
);
   localparam logic [TP_W-1:0] PROG_MASK =
      (TP_W'(1) << PROG_PIN) | (TP_W'(1) << SHARED_PIN);

   if ((FIX_OUT & FIX_IN) != '0 || ((FIX_OUT | FIX_IN) & PROG_MASK) != '0)
      $error("port_timer_mux: fixed masks overlap each other or the programmable lines");

   for (genvar i = 0; i < TP_W; i++) begin : g_line
      if (i == PROG_PIN) begin : g_prog
         assign pin_oe[i]  = ctl.dir_hi;
         assign pin_out[i] = oc_en[i] ? oc_lvl[i] : data_q[i];
         assign ic[i]      = 1'b0;
      end else if (i == SHARED_PIN) begin : g_shared
         assign pin_oe[i]  = ctl.dir_sh;
         assign pin_out[i] = (ctl.sh_oc && oc_en[i]) ? oc_lvl[i] : data_q[i];
         assign ic[i]      = !ctl.sh_oc && pin_in[i];
      end else if (FIX_OUT[i]) begin : g_out
         assign pin_oe[i]  = 1'b1;
         assign pin_out[i] = oc_en[i] ? oc_lvl[i] : data_q[i];
         assign ic[i]      = 1'b0;
      end else if (FIX_IN[i]) begin : g_in
         assign pin_oe[i]  = 1'b0;
         assign pin_out[i] = 1'b0;
         assign ic[i]      = pin_in[i];
      end else begin : g_none
         assign pin_oe[i]  = 1'b0;
         assign pin_out[i] = 1'b0;
         assign ic[i]      = 1'b0;
      end
   end

   assign rd_val = (data_q & pin_oe) | (pin_in & ~pin_oe);

   logic unused_ovr;
   assign unused_ovr = ^(oc_en & ~(FIX_OUT | PROG_MASK)) ^ ^(oc_lvl & ~(FIX_OUT | PROG_MASK));
endmodule

// File: rtl/pinmux_ports.sv
module pinmux_ports
   import pinmux_pkg::*;
#(
   parameter int DW = 8,
   parameter logic [TP_W-1:0] TP_FIX_OUT = 8'h70,
   parameter logic [TP_W-1:0] TP_FIX_IN  = 8'h07,
   localparam int AW = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_exp,
   input  logic          reg_wr,
   input  logic [2:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_rnw,
   input  logic          bus_as,
   input  logic          bus_eclk,
   input  logic          irv_en,
   input  logic          int_rd,
   input  logic [DW-1:0] int_rdata,
   output logic [DW-1:0] bus_rdata,
   output logic [DW-1:0] hp_out,
   input  logic [DW-1:0] cp_in,
   output logic [DW-1:0] cp_out,
   output logic [DW-1:0] cp_oe,
   input  logic [7:0]    tp_in,
   output logic [7:0]    tp_out,
   output logic [7:0]    tp_oe,
   input  logic [7:0]    tmr_oc_en,
   input  logic [7:0]    tmr_oc_lvl,
   output logic [7:0]    tmr_ic
);
   if (DW < TP_W) $error("pinmux_ports: DW must be at least the timer port width");

   logic [TP_W-1:0] td_q;
   tctrl_t          tc_q;
   logic [DW-1:0]   hd_q, cd_q, cdir_q;
   logic [DW-1:0]   c_rd;
   logic [TP_W-1:0] t_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         td_q   <= '0;
         tc_q   <= '0;
         hd_q   <= '0;
         cd_q   <= '0;
         cdir_q <= '0;
      end else if (reg_wr) begin
         unique case (reg_addr)
            RA_TDATA: td_q   <= reg_wdata[TP_W-1:0];
            RA_TCTRL: tc_q   <= '{dir_hi: reg_wdata[TC_DIR_HI],
                                  dir_sh: reg_wdata[TC_DIR_SH],
                                  sh_oc:  reg_wdata[TC_SH_OC]};
            RA_HDATA: hd_q   <= reg_wdata;
            RA_CDATA: cd_q   <= reg_wdata;
            RA_CDIR:  cdir_q <= reg_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_TDATA: reg_rdata = DW'(t_rd);
         RA_TCTRL: begin
            reg_rdata[TC_DIR_HI] = tc_q.dir_hi;
            reg_rdata[TC_DIR_SH] = tc_q.dir_sh;
            reg_rdata[TC_SH_OC]  = tc_q.sh_oc;
         end
         RA_HDATA: reg_rdata = hd_q;
         RA_CDATA: reg_rdata = c_rd;
         RA_CDIR:  reg_rdata = cdir_q;
         default:  reg_rdata = '0;
      endcase
   end

   port_hi_mux #(.DW(DW)) u_hi (
      .mode_exp (mode_exp),
      .data_q   (hd_q),
      .addr_hi  (bus_addr[AW-1:DW]),
      .pin_out  (hp_out)
   );

   port_bidir_mux #(.DW(DW)) u_bidir (
      .mode_exp  (mode_exp),
      .data_q    (cd_q),
      .dir_q     (cdir_q),
      .addr_lo   (bus_addr[DW-1:0]),
      .wdata     (bus_wdata),
      .rnw       (bus_rnw),
      .as_hi     (bus_as),
      .eclk      (bus_eclk),
      .irv_en    (irv_en),
      .int_rd    (int_rd),
      .int_rdata (int_rdata),
      .pin_in    (cp_in),
      .pin_out   (cp_out),
      .pin_oe    (cp_oe),
      .rd_val    (c_rd),
      .ext_rdata (bus_rdata)
   );

   port_timer_mux #(.FIX_OUT(TP_FIX_OUT), .FIX_IN(TP_FIX_IN)) u_timer (
      .data_q  (td_q),
      .ctl     (tc_q),
      .pin_in  (tp_in),
      .oc_en   (tmr_oc_en),
      .oc_lvl  (tmr_oc_lvl),
      .pin_out (tp_out),
      .pin_oe  (tp_oe),
      .rd_val  (t_rd),
      .ic      (tmr_ic)
   );
endmodule

// File: rtl/pinmux_ports_chk.sv
module pinmux_ports_chk #(
   parameter int DW = 8,
   localparam int AW = 2 * DW
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_exp,
   input logic          reg_wr,
   input logic [2:0]    reg_addr,
   input logic [DW-1:0] reg_wdata,
   input logic [AW-1:0] bus_addr,
   input logic          bus_rnw,
   input logic          bus_as,
   input logic          irv_en,
   input logic          int_rd,
   input logic [DW-1:0] hp_out,
   input logic [DW-1:0] cp_out,
   input logic [DW-1:0] cp_oe,
   input logic [7:0]    tp_oe
);
   a_r2_high_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd2) |=> (mode_exp || hp_out == $past(reg_wdata)));

   a_r4_dir_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd4) |=> (mode_exp || cp_oe == $past(reg_wdata)));

   a_r5_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_exp && bus_as) |-> (cp_oe == '1 && cp_out == bus_addr[DW-1:0]));

   a_r7_read_release: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_exp && !bus_as && bus_rnw && !(irv_en && int_rd)) |-> (cp_oe == '0));

   a_r9_fixed_dirs: assert property (@(posedge clk) disable iff (!rst_n)
      (tp_oe[6:4] == 3'b111 && tp_oe[2:0] == 3'b000));

   a_r3_high_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mode_exp |-> (hp_out == bus_addr[AW-1:DW]));
endmodule

bind pinmux_ports pinmux_ports_chk #(.DW(DW)) u_chk (.*);

// File: tb/pinmux_ports_test.sv
`timescale 1ns/1ps
module pinmux_ports_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_exp = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rnw = 1'b1;
   logic        bus_as = 1'b0;
   logic        bus_eclk = 1'b0;
   logic        irv_en = 1'b0;
   logic        int_rd = 1'b0;
   logic [7:0]  int_rdata = '0;
   logic [7:0]  bus_rdata, hp_out, cp_out, cp_oe, tp_out, tp_oe, tmr_ic;
   logic [7:0]  cp_in = '0;
   logic [7:0]  tp_in = '0;
   logic [7:0]  tmr_oc_en = '0;
   logic [7:0]  tmr_oc_lvl = '0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pinmux_ports uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), r);
         chk("R1 reg reset", r, 0);
      end
      chk("R1 hp_out", hp_out, 0);
      chk("R1 cp_oe", cp_oe, 0);
      chk("R1 tp_oe", tp_oe, 8'h70);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 single-chip high port sweep
      for (int v = 0; v < 256; v++) begin
         wr(3'd2, 8'(v));
         chk("R2 hp_out", hp_out, v);
         rd(3'd2, r);
         chk("R2 readback", r, v);
      end

      // R3 expanded high address
      mode_exp = 1'b1;
      wr(3'd2, 8'h5A);
      for (int a = 0; a < 256; a += 7) begin
         bus_addr = {8'(a), ~8'(a)};
         #1 chk("R3 hp_out addr", hp_out, a);
      end
      mode_exp = 1'b0;
      #1 chk("R3 latched while expanded", hp_out, 8'h5A);

      // R4 single-chip bidirectional port
      for (int k = 0; k < 16; k++) begin
         logic [7:0] dir, dat, pin;
         dir = 8'(k * 17) ^ 8'h0F;
         dat = 8'hA5 ^ 8'(k * 29);
         pin = 8'h3C + 8'(k * 11);
         wr(3'd4, dir);
         wr(3'd3, dat);
         cp_in = pin;
         #1;
         chk("R4 cp_oe", cp_oe, dir);
         chk("R4 cp_out", cp_out, dat);
         rd(3'd3, r);
         chk("R4 data read", r, (dat & dir) | (pin & ~dir));
         rd(3'd4, r);
         chk("R4 dir read", r, dir);
      end

      // R5..R8 expanded bus phases
      mode_exp = 1'b1;
      for (int c = 0; c < 32; c++) begin
         logic [7:0] eo, ev;
         string tag;
         bus_as = c[0]; bus_eclk = c[1]; bus_rnw = c[2]; irv_en = c[3]; int_rd = c[4];
         bus_addr = 16'h1200 + 16'(c * 37);
         bus_wdata = 8'h80 ^ 8'(c * 13);
         int_rdata = 8'h41 + 8'(c * 5);
         cp_in = 8'hC3 ^ 8'(c);
         if (c[0]) begin eo = 8'hFF; ev = bus_addr[7:0]; tag = "R5 addr phase"; end
         else if (c[1] && !c[2]) begin eo = 8'hFF; ev = bus_wdata; tag = "R6 write data"; end
         else if (c[1] && c[3] && c[4]) begin eo = 8'hFF; ev = int_rdata; tag = "R8 visibility"; end
         else begin eo = 8'h00; ev = 8'h00; tag = "R7 released"; end
         #1;
         chk(tag, cp_oe, eo);
         if (eo != 0) chk(tag, cp_out, ev);
         chk("R7 bus_rdata", bus_rdata, cp_in);
      end
      bus_as = 1'b0; bus_eclk = 1'b0; bus_rnw = 1'b1; irv_en = 1'b0; int_rd = 1'b0;

      // R9..R13 timer port, both modes
      for (int m = 0; m < 2; m++) begin
         mode_exp = m[0];
         for (int c = 0; c < 8; c++) begin
            logic dh, ds, so;
            logic [7:0] ctlw;
            dh = c[2]; ds = c[1]; so = c[0];
            ctlw = {dh, 3'b000, ds, so, 2'b00} | 8'h73;
            wr(3'd1, ctlw);
            rd(3'd1, r);
            chk("R14 ctrl read", r, {dh, 3'b000, ds, so, 2'b00});
            for (int p = 0; p < 4; p++) begin
               logic [7:0] dat, pin, en, lvl, eoe, ovm, eout, eic;
               dat = 8'h96 ^ 8'(p * 71);
               pin = ~dat ^ 8'(p * 3);
               en  = 8'h5A ^ 8'(p * 37);
               lvl = 8'hC9 ^ 8'(p * 19);
               wr(3'd0, dat);
               tp_in = pin; tmr_oc_en = en; tmr_oc_lvl = lvl;
               #1;
               eoe  = 8'h70 | (dh ? 8'h80 : 8'h00) | (ds ? 8'h08 : 8'h00);
               ovm  = (8'hF0 | (so ? 8'h08 : 8'h00)) & en;
               eout = (lvl & ovm) | (dat & ~ovm);
               eic  = pin & (8'h07 | (!so ? 8'h08 : 8'h00));
               chk(m ? "R13 R9 tp_oe expanded" : "R9 tp_oe", tp_oe, eoe);
               chk(m ? "R13 R11 tp_out expanded" : "R11 tp_out", tp_out & eoe, eout & eoe);
               chk(m ? "R13 R12 tmr_ic expanded" : "R12 tmr_ic", tmr_ic, eic);
               rd(3'd0, r);
               chk(m ? "R13 R10 read expanded" : "R10 read", r, (dat & eoe) | (pin & ~eoe));
            end
         end
      end
      mode_exp = 1'b0;

      // R14 unmapped addresses
      wr(3'd2, 8'h3E);
      wr(3'd4, 8'hF0);
      cp_in = 8'h00;
      for (int a = 5; a < 8; a++) begin
         wr(3'(a), 8'hFF);
         rd(3'(a), r);
         chk("R14 unmapped read", r, 0);
      end
      rd(3'd2, r);
      chk("R14 high unchanged", r, 8'h3E);
      rd(3'd4, r);
      chk("R14 dir unchanged", r, 8'hF0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule